// File: doc/BRIEF.md
# Multi-Channel Transmit Arbiter with Local Loopback

This block sits between a set of per-channel transmit queues and a single physical transmit path. Each channel raises a request together with a frame header: the frame length in bytes, its source MAC address and its destination MAC address. The block picks one requesting channel, checks the frame, and then drains the frame's bytes from that channel at one byte per cycle.

A frame is discarded if its length falls outside the legal window or if its source address differs from the address assigned to the requesting channel. A discarded frame is still drained, so the queue moves on, but none of its bytes leave the block. An accepted frame goes out on the physical stream. When loopback is enabled and the destination is one of the local channel addresses, the frame is returned on a loopback stream instead. Broadcast frames go out on the physical stream and, when loopback is on, are also copied to the loopback stream.

By default the block picks channels in round-robin order. A configuration bit switches it to time slots of programmable length, in which only the slot's owner may start a frame. Seven counters record how many frames end up in each outcome.

Top module: `tx_loop_arbiter`

## Requirements
- R1: A frame whose header length is between 64 and 1538 bytes inclusive is accepted. Length 63 or below increments the too-small counter, and length 1539 or above increments the too-big counter. A discarded frame pops exactly its header length of bytes from its channel and produces no output byte.
- R2: A frame with a legal length whose source address differs from its channel's `ch_mac` entry is discarded. It increments the source-fail counter and produces no output.
- R3: Loopback is enabled after reset. A unicast frame whose destination equals any `ch_mac` entry then appears only on the loopback stream and increments the bypass counter.
- R4: With loopback disabled, frames to local destinations go to the physical stream only, and broadcasts are not copied.
- R5: A destination of all ones (48'hFFFF_FFFF_FFFF) is a broadcast. An accepted broadcast increments the broadcast counter and the transmit counter, and also appears on the loopback stream (incrementing the bypass counter) when loopback is enabled.
- R6: With slots disabled, the next frame goes to the first requesting channel after the previously granted channel, in cyclic order. After reset the search starts at channel 0.
- R7: A granted channel keeps the grant until its whole frame is drained. Bytes leave one per cycle, each one cycle after its pop. The final byte carries the last flag, so an output frame has exactly the header length.
- R8: Time slots are disabled after reset. When enabled with period P, channel k owns the cycles [kP, (k+1)P) modulo NCH·P, counted from the enabling edge. Ownership advances whether or not the owner sends. A frame may start only while its channel owns the slot.
- R9: Every arbitrated frame increments the received counter, and every frame sent to the physical stream increments the transmit counter.
- R10: After reset all stream valids, all pops and all counters are zero.
- R11: At most one channel is popped in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the three configuration fields below |
| cfg_bypass | input | 1 | Loopback enable value (reset value 1) |
| cfg_tdm | input | 1 | Time-slot mode value (reset value 0) |
| cfg_period | input | PW | Slot length in cycles (0 acts as 1) |
| ch_mac | input | NCH*48 | Assigned address of each channel |
| ch_req | input | NCH | Channel has a frame ready |
| ch_len | input | NCH*LW | Frame length in bytes per channel |
| ch_src | input | NCH*48 | Frame source address per channel |
| ch_dst | input | NCH*48 | Frame destination address per channel |
| ch_data | input | NCH*DW | Current frame byte per channel |
| ch_pop | output | NCH | Byte of that channel consumed this cycle |
| phy_valid | output | 1 | Physical stream byte valid |
| phy_data | output | DW | Physical stream byte |
| phy_last | output | 1 | Final byte of a physical frame |
| lb_valid | output | 1 | Loopback stream byte valid |
| lb_data | output | DW | Loopback stream byte |
| lb_last | output | 1 | Final byte of a loopback frame |
| cnt_rcv | output | CW | Frames arbitrated |
| cnt_small | output | CW | Frames dropped as too short |
| cnt_big | output | CW | Frames dropped as too long |
| cnt_srcfail | output | CW | Frames dropped for a source mismatch |
| cnt_bcast | output | CW | Broadcast frames accepted |
| cnt_bypass | output | CW | Frames sent to the loopback stream |
| cnt_xmit | output | CW | Frames sent to the physical stream |

## Verification
The hardest case to reach is a slot-mode request that misses its own slot because another channel's frame is still draining. Ownership keeps rotating underneath the running frame, so the waiting channel must sit out the rest of the cycle of slots. To reach this, the stimulus arms two channels in the first cycle after the edge that enables slots, with a short period and a frame much longer than one slot. It then derives each channel's first pop cycle arithmetically from the slot formula and the first frame's end, and compares it with the observed pops.

// File: rtl/txla_pkg.sv
package txla_pkg;
  localparam int MAC_W = 48;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_XFER = 1'b1} txla_state_t;

  typedef struct packed {
    logic drop;
    logic to_phy;
    logic to_lb;
  } txla_route_t;

  localparam int CNT_RCV    = 0;
  localparam int CNT_SMALL  = 1;
  localparam int CNT_BIG    = 2;
  localparam int CNT_SRC    = 3;
  localparam int CNT_BCAST  = 4;
  localparam int CNT_BYPASS = 5;
  localparam int CNT_XMIT   = 6;
  localparam int NCNT       = 7;
endpackage

// File: rtl/txla_pick.sv
module txla_pick #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic [NCH-1:0] req,
  input  logic [IW-1:0]  last,
  input  logic           tdm_en,
  input  logic [IW-1:0]  owner,
  output logic           any,
  output logic [IW-1:0]  sel
);
  int idx;

  // search starts one past the last grant and wraps
  always_comb begin
    any = 1'b0;
    sel = '0;
    idx = 0;
    for (int k = 1; k <= NCH; k++) begin
      idx = (int'(last) + k) % NCH;
      if (!any && req[idx] && (!tdm_en || (idx[IW-1:0] == owner))) begin
        any = 1'b1;
        sel = idx[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/txla_slot.sv
module txla_slot #(
  parameter int NCH = 4,
  parameter int IW  = 2,
  parameter int PW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] period,
  output logic [IW-1:0] owner
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] own_q, own_d;
  logic          wrap;

  assign wrap = ({1'b0, cnt_q} + (PW+1)'(1)) >= {1'b0, period};

  always_comb begin
    cnt_d = cnt_q;
    own_d = own_q;
    if (!en) begin
      cnt_d = '0;
      own_d = '0;
    end else if (wrap) begin
      cnt_d = '0;
      own_d = (own_q == IW'(NCH-1)) ? '0 : own_q + 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      own_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      own_q <= own_d;
    end
  end

  assign owner = own_q;

  // R8: the owner index never leaves the channel range
  a_r8_owner_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(own_q) < NCH);

  // R8: a slot that is not at its end keeps its owner
  a_r8_owner_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> $stable(own_q));
endmodule

// File: rtl/txla_classify.sv
module txla_classify
  import txla_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int IW      = 2,
  parameter int LW      = 11,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1538
) (
  input  logic [IW-1:0]        sel,
  input  logic [NCH*LW-1:0]    ch_len,
  input  logic [NCH*MAC_W-1:0] ch_src,
  input  logic [NCH*MAC_W-1:0] ch_dst,
  input  logic [NCH*MAC_W-1:0] ch_mac,
  input  logic                 bypass,
  output logic [LW-1:0]        len_sel,
  output logic                 too_small,
  output logic                 too_big,
  output logic                 src_bad,
  output logic                 bcast,
  output txla_route_t          route
);
  logic [MAC_W-1:0] src, dst, own;
  logic             local_hit;

  always_comb begin
    len_sel   = ch_len[sel*LW +: LW];
    src       = ch_src[sel*MAC_W +: MAC_W];
    dst       = ch_dst[sel*MAC_W +: MAC_W];
    own       = ch_mac[sel*MAC_W +: MAC_W];
    local_hit = 1'b0;
    for (int j = 0; j < NCH; j++) begin
      if (dst == ch_mac[j*MAC_W +: MAC_W]) local_hit = 1'b1;
    end
    too_small    = len_sel < LW'(MIN_LEN);
    too_big      = len_sel > LW'(MAX_LEN);
    src_bad      = src != own;
    bcast        = &dst;
    route.drop   = too_small || too_big || src_bad;
    route.to_phy = !route.drop && (bcast || !(bypass && local_hit));
    route.to_lb  = !route.drop && bypass && (bcast || local_hit);
  end
endmodule

// File: rtl/tx_loop_arbiter.sv
module tx_loop_arbiter
  import txla_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int LW          = 11,
  parameter int DW          = 8,
  parameter int PW          = 8,
  parameter int CW          = 16,
  parameter int MIN_LEN     = 64,
  parameter int MAX_LEN     = 1538,
  parameter int DEF_PERIOD  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_bypass,
  input  logic                 cfg_tdm,
  input  logic [PW-1:0]        cfg_period,
  input  logic [NCH*48-1:0]    ch_mac,
  input  logic [NCH-1:0]       ch_req,
  input  logic [NCH*LW-1:0]    ch_len,
  input  logic [NCH*48-1:0]    ch_src,
  input  logic [NCH*48-1:0]    ch_dst,
  input  logic [NCH*DW-1:0]    ch_data,
  output logic [NCH-1:0]       ch_pop,
  output logic                 phy_valid,
  output logic [DW-1:0]        phy_data,
  output logic                 phy_last,
  output logic                 lb_valid,
  output logic [DW-1:0]        lb_data,
  output logic                 lb_last,
  output logic [CW-1:0]        cnt_rcv,
  output logic [CW-1:0]        cnt_small,
  output logic [CW-1:0]        cnt_big,
  output logic [CW-1:0]        cnt_srcfail,
  output logic [CW-1:0]        cnt_bcast,
  output logic [CW-1:0]        cnt_bypass,
  output logic [CW-1:0]        cnt_xmit
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  // configuration
  logic          bypass_q, tdm_q;
  logic [PW-1:0] period_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bypass_q <= 1'b1;
      tdm_q    <= 1'b0;
      period_q <= PW'(DEF_PERIOD);
    end else if (cfg_we) begin
      bypass_q <= cfg_bypass;
      tdm_q    <= cfg_tdm;
      period_q <= cfg_period;
    end
  end

  // slot timer, picker, frame checks
  logic [IW-1:0] owner, sel;
  logic          any;
  logic [LW-1:0] len_sel;
  logic          too_small, too_big, src_bad, bcast;
  txla_route_t   route;
  txla_state_t   st_q, st_d;
  logic [IW-1:0] grant_q, grant_d, last_q, last_d;
  logic [LW-1:0] rem_q, rem_d;
  txla_route_t   route_q, route_d;

  txla_slot #(.NCH(NCH), .IW(IW), .PW(PW)) u_slot (
    .clk(clk), .rst_n(rst_n), .en(tdm_q), .period(period_q), .owner(owner)
  );

  txla_pick #(.NCH(NCH), .IW(IW)) u_pick (
    .req(ch_req), .last(last_q), .tdm_en(tdm_q), .owner(owner),
    .any(any), .sel(sel)
  );

  txla_classify #(.NCH(NCH), .IW(IW), .LW(LW), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_cls (
    .sel(sel), .ch_len(ch_len), .ch_src(ch_src), .ch_dst(ch_dst), .ch_mac(ch_mac),
    .bypass(bypass_q), .len_sel(len_sel), .too_small(too_small), .too_big(too_big),
    .src_bad(src_bad), .bcast(bcast), .route(route)
  );

  // frame sequencing
  logic          start;
  logic          phy_v_d, lb_v_d, last_byte;
  logic [DW-1:0] byte_d;

  assign start = (st_q == ST_IDLE) && any;

  always_comb begin
    st_d      = st_q;
    grant_d   = grant_q;
    last_d    = last_q;
    rem_d     = rem_q;
    route_d   = route_q;
    ch_pop    = '0;
    phy_v_d   = 1'b0;
    lb_v_d    = 1'b0;
    last_byte = 1'b0;
    byte_d    = ch_data[grant_q*DW +: DW];
    case (st_q)
      ST_IDLE: begin
        if (any) begin
          last_d = sel;
          if (len_sel != '0) begin
            st_d    = ST_XFER;
            grant_d = sel;
            rem_d   = len_sel;
            route_d = route;
          end
        end
      end
      default: begin
        ch_pop[grant_q] = 1'b1;
        rem_d           = rem_q - 1'b1;
        phy_v_d         = route_q.to_phy;
        lb_v_d          = route_q.to_lb;
        last_byte       = (rem_q == LW'(1));
        if (rem_q == LW'(1)) st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      grant_q <= '0;
      last_q  <= IW'(NCH-1);
      rem_q   <= '0;
      route_q <= '0;
    end else begin
      st_q    <= st_d;
      grant_q <= grant_d;
      last_q  <= last_d;
      rem_q   <= rem_d;
      route_q <= route_d;
    end
  end

  // output stage, one register after the pop
  logic          phy_v_q, lb_v_q, phy_l_q, lb_l_q;
  logic [DW-1:0] byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_v_q <= 1'b0;
      lb_v_q  <= 1'b0;
      phy_l_q <= 1'b0;
      lb_l_q  <= 1'b0;
      byte_q  <= '0;
    end else begin
      phy_v_q <= phy_v_d;
      lb_v_q  <= lb_v_d;
      phy_l_q <= phy_v_d && last_byte;
      lb_l_q  <= lb_v_d && last_byte;
      if (phy_v_d || lb_v_d) byte_q <= byte_d;
    end
  end

  assign phy_valid = phy_v_q;
  assign phy_last  = phy_l_q;
  assign phy_data  = byte_q;
  assign lb_valid  = lb_v_q;
  assign lb_last   = lb_l_q;
  assign lb_data   = byte_q;

  // outcome counters
  logic [NCNT-1:0]        inc;
  logic [NCNT-1:0][CW-1:0] cnt_q, cnt_d;

  always_comb begin
    inc = '0;
    if (start) begin
      inc[CNT_RCV]   = 1'b1;
      inc[CNT_SMALL] = too_small;
      inc[CNT_BIG]   = too_big;
      inc[CNT_SRC]   = !too_small && !too_big && src_bad;
      if (!route.drop) begin
        inc[CNT_BCAST]  = bcast;
        inc[CNT_BYPASS] = route.to_lb;
        inc[CNT_XMIT]   = route.to_phy;
      end
    end
    for (int c = 0; c < NCNT; c++) begin
      cnt_d[c] = inc[c] ? cnt_q[c] + 1'b1 : cnt_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_rcv     = cnt_q[CNT_RCV];
  assign cnt_small   = cnt_q[CNT_SMALL];
  assign cnt_big     = cnt_q[CNT_BIG];
  assign cnt_srcfail = cnt_q[CNT_SRC];
  assign cnt_bcast   = cnt_q[CNT_BCAST];
  assign cnt_bypass  = cnt_q[CNT_BYPASS];
  assign cnt_xmit    = cnt_q[CNT_XMIT];

  // R11: a single channel is drained at a time
  a_r11_one_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_pop));

  // R7: every output byte follows a pop in the previous cycle
  a_r7_out_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_valid || lb_valid) |-> $past(|ch_pop));

  // R7: the granted channel keeps popping until its frame ends
  a_r7_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_pop && !last_byte) |=> (ch_pop == $past(ch_pop)));

  // R8: in slot mode a frame begins only in its owner's slot
  a_r8_slot_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && tdm_q) |-> (sel == owner));

  // R1: a forwarded frame always has a legal length
  a_r1_fwd_len: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !route.drop) |-> (len_sel >= LW'(MIN_LEN) && len_sel <= LW'(MAX_LEN)));

  // R5: an accepted broadcast always reaches the physical stream
  a_r5_bcast_phy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && bcast && !route.drop) |-> route.to_phy);
endmodule

// File: tb/sim_tx_loop_arbiter.sv
module sim_tx_loop_arbiter;
  localparam int CLK_P = 10;
  localparam int NCH = 4;
  localparam int LW  = 11;
  localparam int DW  = 8;
  localparam int MW  = 48;
  localparam int PW  = 8;
  localparam int CW  = 16;
  localparam logic [MW-1:0] EXT   = 48'h0A0B_0C0D_0E0F;
  localparam logic [MW-1:0] BCAST = 48'hFFFF_FFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_bypass = 1'b1, cfg_tdm = 1'b0;
  logic [PW-1:0] cfg_period = '0;
  logic [NCH*MW-1:0] ch_mac, ch_src, ch_dst;
  logic [NCH*LW-1:0] ch_len;
  logic [NCH*DW-1:0] ch_data;
  logic [NCH-1:0]    ch_req = '0;
  logic [NCH-1:0]    ch_pop;
  logic phy_valid, phy_last, lb_valid, lb_last;
  logic [DW-1:0] phy_data, lb_data;
  logic [CW-1:0] cnt_rcv, cnt_small, cnt_big, cnt_srcfail, cnt_bcast, cnt_bypass, cnt_xmit;

  logic [LW-1:0] blen [NCH];
  logic [MW-1:0] bsrc [NCH];
  logic [MW-1:0] bdst [NCH];

  function automatic logic [MW-1:0] mac_of(int i);
    return 48'h0200_0000_0010 + MW'(i);
  endfunction

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign ch_mac[g*MW +: MW]  = mac_of(g);
    assign ch_src[g*MW +: MW]  = bsrc[g];
    assign ch_dst[g*MW +: MW]  = bdst[g];
    assign ch_len[g*LW +: LW]  = blen[g];
    assign ch_data[g*DW +: DW] = 8'h10 + DW'(g);
  end

  tx_loop_arbiter #(.NCH(NCH), .LW(LW), .DW(DW), .PW(PW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bypass(cfg_bypass),
    .cfg_tdm(cfg_tdm), .cfg_period(cfg_period), .ch_mac(ch_mac), .ch_req(ch_req),
    .ch_len(ch_len), .ch_src(ch_src), .ch_dst(ch_dst), .ch_data(ch_data),
    .ch_pop(ch_pop), .phy_valid(phy_valid), .phy_data(phy_data), .phy_last(phy_last),
    .lb_valid(lb_valid), .lb_data(lb_data), .lb_last(lb_last),
    .cnt_rcv(cnt_rcv), .cnt_small(cnt_small), .cnt_big(cnt_big),
    .cnt_srcfail(cnt_srcfail), .cnt_bcast(cnt_bcast), .cnt_bypass(cnt_bypass),
    .cnt_xmit(cnt_xmit)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // monitor: pop bookkeeping and frame logging at the falling edge
  int  rem [NCH];
  int  pops [NCH];
  int  first_pop [NCH];
  bit  infr [NCH];
  int  phy_n = 0, lb_n = 0, pc = 0, lc = 0, pfirst = 0;
  int  phy_tag [64], phy_cnt [64], phy_fc [64], lb_tag [64], lb_cnt [64];
  bit  phy_ok [64], lb_ok [64];
  logic [DW-1:0] ptag, ltag;
  bit  pok, lok;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        if (ch_pop[i]) begin
          if (!infr[i]) begin infr[i] = 1'b1; first_pop[i] = cyc; end
          pops[i]++;
          rem[i]--;
          if (rem[i] == 0) begin infr[i] = 1'b0; ch_req[i] = 1'b0; end
        end
      end
      if (phy_valid) begin
        if (pc == 0) begin ptag = phy_data; pok = 1'b1; pfirst = cyc; end
        else if (phy_data != ptag) pok = 1'b0;
        pc++;
        if (phy_last) begin
          phy_tag[phy_n] = int'(ptag); phy_cnt[phy_n] = pc;
          phy_ok[phy_n] = pok; phy_fc[phy_n] = pfirst;
          phy_n++; pc = 0;
        end
      end
      if (lb_valid) begin
        if (lc == 0) begin ltag = lb_data; lok = 1'b1; end
        else if (lb_data != ltag) lok = 1'b0;
        lc++;
        if (lb_last) begin
          lb_tag[lb_n] = int'(ltag); lb_cnt[lb_n] = lc; lb_ok[lb_n] = lok;
          lb_n++; lc = 0;
        end
      end
    end
  end

  task automatic arm(int ch, int len, logic [MW-1:0] src, logic [MW-1:0] dst);
    blen[ch] = LW'(len); bsrc[ch] = src; bdst[ch] = dst;
    rem[ch] = len; pops[ch] = 0; infr[ch] = 1'b0;
    ch_req[ch] = 1'b1;
  endtask

  task automatic send(int ch, int len, logic [MW-1:0] src, logic [MW-1:0] dst);
    @(negedge clk);
    arm(ch, len, src, dst);
    wait (ch_req[ch] == 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg(bit byp, bit tdm, int per);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bypass = byp; cfg_tdm = tdm; cfg_period = PW'(per);
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  int e_rcv = 0, e_small = 0, e_big = 0, e_src = 0, e_bc = 0, e_byp = 0, e_xm = 0;

  task automatic chk_counters(string tag);
    chk({tag, " R9 rcv"},       cnt_rcv,     e_rcv);
    chk({tag, " R1 small"},     cnt_small,   e_small);
    chk({tag, " R1 big"},       cnt_big,     e_big);
    chk({tag, " R2 srcfail"},   cnt_srcfail, e_src);
    chk({tag, " R5 bcast"},     cnt_bcast,   e_bc);
    chk({tag, " R3 bypass"},    cnt_bypass,  e_byp);
    chk({tag, " R9 xmit"},      cnt_xmit,    e_xm);
  endtask

  function automatic int next_slot(int from, int ch, int p);
    int c = from;
    while (((c / p) % NCH) != ch) c++;
    return c;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p0, l0, rr_last, c0, exp1, exp3;
    for (int i = 0; i < NCH; i++) begin
      blen[i] = '0; bsrc[i] = '0; bdst[i] = '0; rem[i] = 0; pops[i] = 0; infr[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 phy_valid", phy_valid, 0);
    chk("R10 lb_valid", lb_valid, 0);
    chk("R10 ch_pop", ch_pop, 0);
    chk("R10 cnt_rcv", cnt_rcv, 0);
    chk("R10 cnt_xmit", cnt_xmit, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1/R7: minimum legal length to the physical stream
    send(0, 64, mac_of(0), EXT);
    e_rcv++; e_xm++;
    chk("R1 min frame logged", phy_n, 1);
    chk("R7 min frame bytes", phy_cnt[0], 64);
    chk("R7 min frame tag", phy_tag[0], 'h10);
    chk("R7 min frame contiguous", phy_ok[0], 1);
    chk("R7 one-cycle latency", phy_fc[0], first_pop[0] + 1);
    chk("R3 no loopback for external", lb_n, 0);
    chk_counters("S1");

    // R1: too small, drained silently
    send(1, 63, mac_of(1), EXT);
    e_rcv++; e_small++;
    chk("R1 small drained", pops[1], 63);
    chk("R1 small no output", phy_n + lb_n, 1);
    // R1: too big
    send(2, 1539, mac_of(2), EXT);
    e_rcv++; e_big++;
    chk("R1 big drained", pops[2], 1539);
    chk("R1 big no output", phy_n + lb_n, 1);
    // R1: maximum legal length
    send(3, 1538, mac_of(3), EXT);
    e_rcv++; e_xm++;
    chk("R1 max frame bytes", phy_cnt[1], 1538);
    chk("R7 max frame contiguous", phy_ok[1], 1);
    // R2: wrong source
    send(1, 64, mac_of(2), EXT);
    e_rcv++; e_src++;
    chk("R2 src drained", pops[1], 64);
    chk("R2 src no output", phy_n + lb_n, 2);
    chk_counters("S5");

    // R3: loopback enabled by reset, local unicast
    send(1, 100, mac_of(1), mac_of(2));
    e_rcv++; e_byp++;
    chk("R3 loopback frame", lb_n, 1);
    chk("R3 loopback bytes", lb_cnt[0], 100);
    chk("R3 loopback tag", lb_tag[0], 'h11);
    chk("R3 loopback contiguous", lb_ok[0], 1);
    chk("R3 not on phy", phy_n, 2);
    // R5: broadcast with loopback on
    send(2, 80, mac_of(2), BCAST);
    e_rcv++; e_bc++; e_byp++; e_xm++;
    chk("R5 bcast phy", phy_cnt[2], 80);
    chk("R5 bcast lb", lb_cnt[1], 80);
    chk("R5 bcast lb tag", lb_tag[1], 'h12);
    chk_counters("S7");

    // R4: loopback off
    cfg(1'b0, 1'b0, 16);
    send(0, 70, mac_of(0), mac_of(3));
    e_rcv++; e_xm++;
    chk("R4 local to phy", phy_cnt[3], 70);
    chk("R4 no loopback", lb_n, 2);
    send(1, 64, mac_of(1), BCAST);
    e_rcv++; e_bc++; e_xm++;
    chk("R4 bcast phy only", phy_n, 5);
    chk("R4 bcast no copy", lb_n, 2);
    chk_counters("S8");
    rr_last = 1;

    // R6: round robin from the channel after the last grant
    p0 = phy_n;
    @(negedge clk);
    for (int i = 0; i < NCH; i++) arm(i, 64, mac_of(i), EXT);
    wait (ch_req == '0);
    repeat (3) @(negedge clk);
    e_rcv += NCH; e_xm += NCH;
    chk("R6 frames", phy_n - p0, NCH);
    for (int k = 0; k < NCH; k++) begin
      chk($sformatf("R6 order slot %0d", k), phy_tag[p0+k], 'h10 + ((rr_last + 1 + k) % NCH));
      chk($sformatf("R7 rr frame %0d bytes", k), phy_cnt[p0+k], 64);
      chk($sformatf("R7 rr frame %0d contiguous", k), phy_ok[p0+k], 1);
    end

    // R8: time slots of period 4, two channels armed in cycle 0
    p0 = phy_n;
    cfg(1'b1, 1'b1, 4);
    @(negedge clk);
    c0 = cyc;
    arm(1, 64, mac_of(1), EXT);
    arm(3, 64, mac_of(3), EXT);
    wait (ch_req == '0);
    repeat (3) @(negedge clk);
    e_rcv += 2; e_xm += 2;
    exp1 = next_slot(0, 1, 4) + 1;
    l0   = exp1 + 64;
    exp3 = next_slot(l0, 3, 4) + 1;
    chk("R8 ch1 first pop", first_pop[1] - c0, exp1);
    chk("R8 ch3 first pop", first_pop[3] - c0, exp3);
    chk("R8 order first", phy_tag[p0], 'h11);
    chk("R8 order second", phy_tag[p0+1], 'h13);
    chk_counters("END");
    finish_run();
  end
endmodule